// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block turns a single processor-side load or store of an aligned byte, word or long word into one or more cycles on an external 32-bit data bus. The width of the addressed device is not known beforehand. Each bus cycle ends when the device returns a two-bit acknowledge code. That code either stretches the cycle with wait states or completes it and states whether the device is 8, 16 or 32 bits wide. The controller moves as many bytes as the reported width allows, then runs further cycles until the whole operand has been moved.

On writes the controller places the remaining operand bytes on the byte lanes so that a device of any width finds valid data on the lanes it uses. On reads it takes each device's bytes from the lanes that device drives and packs them, most significant first, into a right-justified result. The processor side sees a single request, a single one-cycle completion pulse and the assembled read data.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, `bus_cyc` and `done` are 0 and `req_ready` is 1.
- R2: A request with `req_valid` high while `req_ready` is 1 starts a bus cycle in the next clock. In that cycle `bus_cyc` is 1, `bus_addr` equals `req_addr`, `bus_we` equals `req_write`, and `bus_siz` holds the full operand byte count. The count code is 01 = 1 byte, 10 = 2 bytes, 11 = 3 bytes and 00 = 4 bytes. The request size code is 00 = byte, 01 = word and 10 = long word, with 11 treated as a long word.
- R3: While `bus_ack_n` is 11 (wait), the cycle is held. `bus_cyc`, `bus_addr`, `bus_we`, `bus_siz` and `bus_wdata` stay unchanged into the next clock.
- R4: A completing code reports the port width: 00 = 32-bit on lanes 31:0, 01 = 16-bit on lanes 31:16, 10 = 8-bit on lanes 31:24. Lane 31:24 is lane 0. A P-byte port uses lanes 0..P-1, and the byte at address A sits on lane (A mod P). The cycle moves min(remaining, P - (A mod P)) bytes. On writes, exactly those bytes reach the device's memory.
- R5: After a completion that leaves bytes outstanding, the next clock keeps `bus_cyc` high. It raises `bus_addr` by the number of bytes moved and lowers the count in `bus_siz` by the same amount.
- R6: On writes, with remaining bytes b0 (next, most significant) onward and offset a = `bus_addr` mod 4, lane L carries a byte chosen as follows. It is b(L-a) when that byte exists. Otherwise it is b((L mod 2)-(a mod 2)) when that byte exists. Otherwise it is b0.
- R7: On reads, `rd_data` holds the operand's bytes in address order, most significant first, right-justified with zero upper bytes. It is valid from the `done` pulse on.
- R8: `done` is a one-clock pulse in the clock after the final completing acknowledge. In that clock `bus_cyc` is 0 and `req_ready` is 1.
- R9: An n-byte aligned operand on a P-byte port takes max(1, n/P) bus cycles. With W wait clocks per cycle, `done` rises (W+1) clocks after the start of each of those cycles.
- R10: Requests presented while a transfer is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Operand address, aligned to its size |
| req_wdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read operand, right-justified |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | ADDR_W | Address of the next byte to move |
| bus_siz | output | 2 | Remaining byte count code |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the device |
| bus_ack_n | input | 2 | Acknowledge and port-width code |

## Verification
The bench sweeps every aligned placement of byte, word and long-word operands, both directions, against a device model answering as an 8-, 16- and 32-bit port with zero and two wait clocks. Read results tell apart errors in lane extraction and byte packing order. Write results, with the untouched neighbour bytes, show wrong lane steering or overwrites beyond the operand. The number of bus cycles, their addresses and the completion latency separate a wrong split of the operand from a wrong address step or wrong wait handling. A request issued in the middle of a slow transfer shows whether busy-time requests leak in.

// File: rtl/dyn_bus_sizer_pkg.sv
package dyn_bus_sizer_pkg;

    localparam int LANES = 4;
    localparam int BUS_W = 8 * LANES;

    typedef enum logic [1:0] {
        ACK_W32  = 2'b00,
        ACK_W16  = 2'b01,
        ACK_W8   = 2'b10,
        ACK_WAIT = 2'b11
    } ack_code_e;

    typedef enum logic [1:0] {
        OPSZ_BYTE = 2'b00,
        OPSZ_WORD = 2'b01,
        OPSZ_LONG = 2'b10,
        OPSZ_RSV  = 2'b11
    } op_size_e;

    // operand size code -> byte count (1, 2 or 4)
    function automatic logic [2:0] op_bytes(input logic [1:0] sz);
        case (sz)
            OPSZ_BYTE: return 3'd1;
            OPSZ_WORD: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

    // bus count code -> byte count (00 means four)
    function automatic logic [2:0] siz_count(input logic [1:0] code);
        return {code == 2'b00, code};
    endfunction

endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
    import dyn_bus_sizer_pkg::*;
(
    input  logic [1:0] ack_n,
    input  logic [1:0] offs,
    input  logic [2:0] rem,
    output logic       complete,
    output logic [1:0] port_off,
    output logic [2:0] moved
);
    logic [2:0] port_bytes;
    logic [2:0] room;

    always_comb begin
        complete = (ack_n != ACK_WAIT);
        case (ack_n)
            ACK_W16: begin port_bytes = 3'd2; port_off = {1'b0, offs[0]}; end
            ACK_W8:  begin port_bytes = 3'd1; port_off = 2'd0;            end
            default: begin port_bytes = 3'd4; port_off = offs;            end
        endcase
        room  = port_bytes - {1'b0, port_off};
        moved = (rem < room) ? rem : room;
    end

endmodule

// File: rtl/dbs_wlane_steer.sv
module dbs_wlane_steer
    import dyn_bus_sizer_pkg::*;
(
    input  logic [BUS_W-1:0] rem_data,   // remaining bytes, next byte at 31:24
    input  logic [1:0]       offs,
    input  logic [2:0]       rem,
    output logic [BUS_W-1:0] lanes
);
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [2:0] lane_c, lane_h, d32, d16;
        logic       v32, v16;
        logic [1:0] idx;
        logic [7:0] sel;

        always_comb begin
            lane_c = 3'(L);
            lane_h = 3'(L % 2);
            d32    = lane_c - {1'b0, offs};
            d16    = lane_h - {2'b00, offs[0]};
            v32    = (lane_c >= {1'b0, offs}) && (d32 < rem);
            v16    = (lane_h >= {2'b00, offs[0]}) && (d16 < rem);
            if (v32)      idx = d32[1:0];
            else if (v16) idx = d16[1:0];
            else          idx = 2'd0;
            sel = rem_data[8*(LANES-1-int'(idx)) +: 8];
        end

        assign lanes[8*(LANES-1-L) +: 8] = sel;
    end

endmodule

// File: rtl/dbs_rd_gather.sv
module dbs_rd_gather
    import dyn_bus_sizer_pkg::*;
(
    input  logic [BUS_W-1:0] bus_rdata,
    input  logic [1:0]       port_off,
    input  logic [2:0]       moved,
    output logic [BUS_W-1:0] got          // moved bytes, right-justified
);
    logic [BUS_W-1:0] aligned;

    always_comb begin
        aligned = bus_rdata << {port_off, 3'b000};
        got     = aligned >> {3'd4 - moved, 3'b000};
    end

endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
    import dyn_bus_sizer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              done,
    output logic [BUS_W-1:0]  rd_data,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic [1:0]        bus_ack_n
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        rem;
        logic [BUS_W-1:0]  wq;
        logic [BUS_W-1:0]  acc;
        logic              done;
        logic [BUS_W-1:0]  rdata;
    } st_t;

    st_t s_q, s_d;

    logic             complete;
    logic [1:0]       port_off;
    logic [2:0]       moved;
    logic [BUS_W-1:0] got;
    logic [BUS_W-1:0] steer;
    logic [BUS_W-1:0] acc_next;
    logic [2:0]       new_bytes;

    dbs_ack_decode u_ack (
        .ack_n    (bus_ack_n),
        .offs     (s_q.addr[1:0]),
        .rem      (s_q.rem),
        .complete (complete),
        .port_off (port_off),
        .moved    (moved)
    );

    dbs_rd_gather u_gather (
        .bus_rdata (bus_rdata),
        .port_off  (port_off),
        .moved     (moved),
        .got       (got)
    );

    dbs_wlane_steer u_steer (
        .rem_data (s_q.wq),
        .offs     (s_q.addr[1:0]),
        .rem      (s_q.rem),
        .lanes    (steer)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        new_bytes = op_bytes(req_size);
        acc_next  = (s_q.acc << {moved, 3'b000}) | got;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy = 1'b1;
                s_d.we   = req_write;
                s_d.addr = req_addr;
                s_d.rem  = new_bytes;
                s_d.wq   = req_wdata << {3'd4 - new_bytes, 3'b000};
                s_d.acc  = '0;
            end
        end else if (complete) begin
            s_d.acc = acc_next;
            if (moved == s_q.rem) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.rem  = 3'd0;
                if (!s_q.we) s_d.rdata = acc_next;
            end else begin
                s_d.addr = s_q.addr + ADDR_W'(moved);
                s_d.rem  = s_q.rem - moved;
                s_d.wq   = s_q.wq << {moved, 3'b000};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = !s_q.busy;
    assign done      = s_q.done;
    assign rd_data   = s_q.rdata;
    assign bus_cyc   = s_q.busy;
    assign bus_we    = s_q.we;
    assign bus_addr  = s_q.addr;
    assign bus_siz   = s_q.rem[1:0];
    assign bus_wdata = (s_q.busy && s_q.we) ? steer : '0;

    AST_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_cyc && bus_addr == $past(req_addr) && bus_we == $past(req_write))); // R2
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack_n == 2'b11) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_we) && $stable(bus_wdata))); // R3
    AST_ADDR_PLUS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack_n != 2'b11) |=> (!bus_cyc || (bus_addr + ADDR_W'(siz_count(bus_siz))) == $past(bus_addr + ADDR_W'(siz_count(bus_siz))))); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_cyc && req_ready)); // R8
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_cyc) && $past(bus_ack_n) != 2'b11)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

// File: tb/dyn_bus_sizer_tb.sv
module dyn_bus_sizer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rd_data;
    logic        bus_cyc;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_siz;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_ack_n = 2'b11;

    always #4 clk = ~clk;

    dyn_bus_sizer #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_siz(bus_siz),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // device model
    logic [7:0]  mem [16];
    logic [31:0] cyc_addr [8];
    int dev_w = 4, dev_wait = 0, wcnt = 0, bus_cycles = 0;
    int dv_a, dv_off, dv_base, dv_rem;

    always @(negedge clk) begin
        if (bus_cyc) begin
            if (wcnt < dev_wait) begin
                bus_ack_n = 2'b11;
                wcnt++;
            end else begin
                dv_a    = int'(bus_addr[3:0]);
                dv_off  = dv_a % dev_w;
                dv_base = dv_a - dv_off;
                dv_rem  = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
                bus_ack_n = (dev_w == 4) ? 2'b00 : (dev_w == 2) ? 2'b01 : 2'b10;
                bus_rdata = 32'hEEEE_EEEE;
                for (int l = 0; l < dev_w; l++) bus_rdata[31-8*l -: 8] = mem[dv_base+l];
                if (bus_we)
                    for (int l = dv_off; l < dev_w; l++)
                        if (l - dv_off < dv_rem) mem[dv_base+l] = bus_wdata[31-8*l -: 8];
                if (bus_cycles < 8) cyc_addr[bus_cycles] = bus_addr;
                bus_cycles++;
                wcnt = 0;
            end
        end else begin
            bus_ack_n = 2'b11;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 17 + 3);
    endfunction

    // R6 lane rule, first cycle (remaining = n)
    function automatic logic [31:0] exp_lanes(input logic [31:0] d, input int n, input int off);
        logic [7:0] b [4];
        logic [31:0] v;
        int h;
        for (int i = 0; i < 4; i++) b[i] = 8'h00;
        for (int i = 0; i < n; i++) b[i] = d[8*(n-1-i) +: 8];
        for (int L = 0; L < 4; L++) begin
            h = (L % 2) - (off % 2);
            if (L >= off && L - off < n) v[31-8*L -: 8] = b[L-off];
            else if (h >= 0 && h < n)   v[31-8*L -: 8] = b[h];
            else                        v[31-8*L -: 8] = b[0];
        end
        return v;
    endfunction

    task automatic run_xfer(input bit wr, input int n, input int off, input int pw,
                            input int ws, input logic [31:0] data_in);
        logic [31:0] addr, data, exp, first_addr, first_wd;
        int lat, ncyc, idx;
        bit ok;
        data = (n == 4) ? data_in : (data_in & ((32'h1 << (8*n)) - 1));
        addr = 32'h0000_0104 + 32'(off);
        for (int i = 0; i < 16; i++) mem[i] = init_byte(i);
        dev_w = pw; dev_wait = ws; bus_cycles = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        req_size  = (n == 1) ? 2'b00 : (n == 2) ? 2'b01 : 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cyc && bus_addr == addr && bus_we == wr && bus_siz == 2'(n), "R2 first cycle",
            {bus_addr[23:0], 2'b0, bus_we, bus_cyc, 2'b0, bus_siz}, {addr[23:0], 2'b0, wr, 1'b1, 2'b0, 2'(n)});
        if (wr) chk(bus_wdata == exp_lanes(data, n, off), "R6 write lanes", bus_wdata, exp_lanes(data, n, off));
        first_addr = bus_addr; first_wd = bus_wdata;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (ws > 0 && lat == 1)
                chk(bus_cyc && bus_addr == first_addr && bus_wdata == first_wd, "R3 hold during wait",
                    bus_addr, first_addr);
        end
        ncyc = (n > pw) ? n / pw : 1;
        chk(lat == ncyc * (ws + 1), "R9 latency", 32'(lat), 32'(ncyc * (ws + 1)));
        chk(bus_cycles == ncyc, "R9 bus cycles", 32'(bus_cycles), 32'(ncyc));
        ok = 1'b1;
        for (int k = 0; k < ncyc && k < 8; k++) if (cyc_addr[k] != addr + 32'(k * ((n > pw) ? pw : n))) ok = 1'b0;
        chk(ok, "R5 cycle addresses", cyc_addr[ncyc > 1 ? 1 : 0], addr + 32'((ncyc > 1) ? pw : 0));
        chk(done && !bus_cyc && req_ready, "R8 done state", {29'b0, done, bus_cyc, req_ready}, 32'h5);
        if (wr) begin
            ok = 1'b1;
            for (int i = 0; i < 16; i++) begin
                idx = i - (4 + off);
                if (idx >= 0 && idx < n) begin
                    if (mem[i] != data[8*(n-1-idx) +: 8]) ok = 1'b0;
                end else if (mem[i] != init_byte(i)) ok = 1'b0;
            end
            chk(ok, "R4 written bytes", {mem[4], mem[5], mem[6], mem[7]}, data);
        end else begin
            exp = '0;
            for (int i = 0; i < n; i++) exp = (exp << 8) | 32'(init_byte(4 + off + i));
            chk(rd_data == exp, "R7 read data", rd_data, exp);
        end
        @(posedge clk);
        @(negedge clk);
        chk(!done && !bus_cyc, "R8 single pulse", {30'b0, done, bus_cyc}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        int lat;
        bit ok;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_cyc && !done && req_ready, "R1 reset state", {29'b0, bus_cyc, done, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_cyc && !done && req_ready, "R1 after release", {29'b0, bus_cyc, done, req_ready}, 32'h1);

        for (int wr = 0; wr < 2; wr++)
            for (int ni = 0; ni < 3; ni++)
                for (int pi = 0; pi < 3; pi++)
                    for (int ws = 0; ws <= 2; ws += 2)
                        for (int off = 0; off < 4; off += (1 << ni))
                            run_xfer(wr[0], 1 << ni, off, 1 << pi, ws,
                                     32'hA1B2_C3D4 ^ 32'(off * 32'h0101_0101 + pi * 32'h1000_0010 + ws));

        // R10: request during a busy transfer is ignored
        for (int i = 0; i < 16; i++) mem[i] = init_byte(i);
        dev_w = 1; dev_wait = 2; bus_cycles = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'b10; req_addr = 32'h0000_0104; req_wdata = '0;
        @(negedge clk);
        req_write = 1'b1; req_size = 2'b00; req_addr = 32'h0000_010B; req_wdata = 32'h0000_005A;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 3) chk(bus_addr == 32'h0000_0104 || bus_addr == 32'h0000_0105, "R10 address kept",
                              bus_addr, 32'h0000_0105);
        end
        req_valid = 1'b0;
        exp = {init_byte(4), init_byte(5), init_byte(6), init_byte(7)};
        chk(rd_data == exp, "R10 original read result", rd_data, exp);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (mem[i] != init_byte(i)) ok = 1'b0;
        chk(ok, "R10 no stray write", {31'b0, ok}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        chk(!bus_cyc, "R10 no new cycle after done", {31'b0, bus_cyc}, 32'h0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule